// File: doc/BRIEF.md
# Low-Power Idle Controller

This block puts a small microcontroller into a low-power idle state and brings it back out. Software picks the idle variant through a two-bit mode register and then sets a stop bit in a control register. After a fixed entry delay, the block drops the clock enables of the CPU and of the peripheral domain. The oscillator, PLL and flash enables stay high the whole time. Because those clocks never stop, the return to normal operation needs no stabilization wait.

While idle, the block watches several wake sources: a non-maskable pin, a watchdog request, eight external interrupt lines, and a vector of internal peripheral requests. Three mask bits in the control register can stop chosen source groups from waking the device. Reset also ends idle.

Waking up is kept separate from accepting the interrupt. When the block leaves idle, it compares the priority of the waking request with the in-service level from the interrupt controller. It then emits one of two one-cycle pulses: an acknowledge pulse, or a hold pulse that leaves the request pending.

Top module: `lp_idle_ctrl`

## Requirements
- R1: After reset the state is normal (status code 0), the mode field reads 00, and the stop bit and all three mask bits read 0.
- R2: A control write with the stop bit (bit 0) set starts idle entry only when the mode field (mode register at address 0, bits 1:0) is 00 and the state is normal. Otherwise the stop bit stays 0 and the state stays normal.
- R3: After the accepting write, the status output reads entering (code 1) for ENTRY_DELAY cycles and then idle (code 2). The CPU and peripheral enables stay high while entering.
- R4: While idle, the CPU and peripheral clock enables are 0. The oscillator, PLL and flash enables are 1 in every state.
- R5: Each wake source ends idle: the NMI pin, the watchdog request, any external line whose enable bit is 1, and any peripheral request. An external line whose enable bit is 0 does not end idle.
- R6: Control register bit 1 blocks the NMI pin, bit 2 blocks the watchdog, and bit 3 blocks the external and peripheral requests. A blocked request leaves the device idle.
- R7: The state becomes normal on the first clock edge at which an unblocked wake is seen, with no stabilization delay. At that edge the stop bit clears and the mask bits keep their values (control register at address 1).
- R8: On leaving idle, exactly one of wake_ack and wake_hold pulses for one cycle. An NMI-pin or watchdog wake is always acknowledged. A maskable wake is acknowledged when no service is active, or when req_level is greater than svc_level. Otherwise it is held.
- R9: The NMI pin and the external lines pass through a two-stage synchronizer, so they end idle two cycles later than the watchdog and peripheral requests.
- R10: An asynchronous reset during idle returns the state to normal and raises the CPU and peripheral enables without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 mode, 1 control |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected register |
| nmi_pin | input | 1 | Non-maskable pin request (asynchronous) |
| wdt_irq | input | 1 | Watchdog non-maskable request |
| ext_irq | input | N_EXT | External interrupt lines (asynchronous) |
| ext_irq_en | input | N_EXT | Per-line enable from the interrupt controller |
| periph_irq | input | N_PERIPH | Unmasked internal peripheral requests |
| in_service | input | 1 | An interrupt is currently being serviced |
| svc_level | input | PRIO_W | Priority of the request in service |
| req_level | input | PRIO_W | Priority of the highest pending maskable request |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| flash_en | output | 1 | Flash enable |
| idle_state | output | 2 | 0 normal, 1 entering, 2 idle |
| wake_ack | output | 1 | One-cycle pulse: the waking request is accepted |
| wake_hold | output | 1 | One-cycle pulse: idle ended but the request stays pending |

## Verification
Any error in the state register appears on the status output and on the two gated enables at the next sampling point. An entry counter that is off by one moves the entering-to-idle change by a cycle, and the exact-cycle checks in the entry sequence detect that shift. A wrong mask decode or a wrong synchronizer depth shows up within three cycles of a wake stimulus, because the device either stays idle or leaves at the wrong edge. A wrong priority comparison shows up as the wrong pulse on the cycle the device leaves idle.

// File: rtl/lp_idle_pkg.sv
`timescale 1ns/1ps
package lp_idle_pkg;
   typedef enum logic [1:0] {
      ST_NORMAL = 2'd0,
      ST_ENTER  = 2'd1,
      ST_IDLE   = 2'd2
   } idle_state_t;

   localparam logic ADDR_MODE = 1'b0;
   localparam logic ADDR_CTRL = 1'b1;

   localparam int CTRL_STOP  = 0;
   localparam int CTRL_MNMI  = 1;
   localparam int CTRL_MWDT  = 2;
   localparam int CTRL_MMASK = 3;
endpackage

// File: rtl/lp_idle_sync.sv
`timescale 1ns/1ps
module lp_idle_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("lp_idle_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/lp_idle_regs.sv
`timescale 1ns/1ps
module lp_idle_regs
   import lp_idle_pkg::*;
#(
   parameter int DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              is_normal,
   input  logic              clr_stop,
   output logic              entry_go,
   output logic              m_nmi,
   output logic              m_wdt,
   output logic              m_mask,
   output logic [DATA_W-1:0] rdata
);
   logic [1:0] mode_q;
   logic       stop_q;

   assign entry_go = we && (addr == ADDR_CTRL) && wdata[CTRL_STOP]
                     && (mode_q == 2'b00) && is_normal;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 2'b00;
         stop_q <= 1'b0;
         m_nmi  <= 1'b0;
         m_wdt  <= 1'b0;
         m_mask <= 1'b0;
      end else begin
         if (we && addr == ADDR_MODE) mode_q <= wdata[1:0];
         if (we && addr == ADDR_CTRL) begin
            m_nmi  <= wdata[CTRL_MNMI];
            m_wdt  <= wdata[CTRL_MWDT];
            m_mask <= wdata[CTRL_MMASK];
         end
         if (clr_stop)      stop_q <= 1'b0;
         else if (entry_go) stop_q <= 1'b1;
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == ADDR_MODE) rdata[1:0] = mode_q;
      else                   rdata[3:0] = {m_mask, m_wdt, m_nmi, stop_q};
   end

   // R2: an accepted entry write sets the stop bit
   assert_stop_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      entry_go |=> stop_q);
   // R7: leaving idle clears the stop bit
   assert_stop_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_stop |=> !stop_q);
endmodule

// File: rtl/lp_idle_wake.sv
`timescale 1ns/1ps
module lp_idle_wake #(
   parameter int N_EXT    = 8,
   parameter int N_PERIPH = 4,
   parameter int PRIO_W   = 3
) (
   input  logic                nmi_s,
   input  logic                wdt_irq,
   input  logic [N_EXT-1:0]    ext_s,
   input  logic [N_EXT-1:0]    ext_en,
   input  logic [N_PERIPH-1:0] periph_irq,
   input  logic                m_nmi,
   input  logic                m_wdt,
   input  logic                m_mask,
   input  logic                in_service,
   input  logic [PRIO_W-1:0]   svc_level,
   input  logic [PRIO_W-1:0]   req_level,
   output logic                wake,
   output logic                ack_dec
);
   logic nonmask_wake, mask_wake, outranks;

   assign nonmask_wake = (nmi_s & ~m_nmi) | (wdt_irq & ~m_wdt);
   assign mask_wake    = ~m_mask & ((|(ext_s & ext_en)) | (|periph_irq));
   assign outranks     = ~in_service | (req_level > svc_level);
   assign wake         = nonmask_wake | mask_wake;
   assign ack_dec      = nonmask_wake | (mask_wake & outranks);
endmodule

// File: rtl/lp_idle_fsm.sv
`timescale 1ns/1ps
module lp_idle_fsm
   import lp_idle_pkg::*;
#(
   parameter int ENTRY_DELAY = 5
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        entry_go,
   input  logic        wake,
   input  logic        ack_dec,
   output idle_state_t st,
   output logic        clr_stop,
   output logic        ack_q,
   output logic        hold_q
);
   localparam int CNT_W = (ENTRY_DELAY > 1) ? $clog2(ENTRY_DELAY) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(ENTRY_DELAY - 1);

   logic [CNT_W-1:0] cnt;

   assign clr_stop = (st == ST_IDLE) && wake;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_NORMAL;
         cnt    <= '0;
         ack_q  <= 1'b0;
         hold_q <= 1'b0;
      end else begin
         ack_q  <= 1'b0;
         hold_q <= 1'b0;
         unique case (st)
            ST_NORMAL: if (entry_go) begin
               st  <= ST_ENTER;
               cnt <= '0;
            end
            ST_ENTER: begin
               if (cnt == LAST) st <= ST_IDLE;
               else             cnt <= cnt + 1'b1;
            end
            ST_IDLE: if (wake) begin
               st     <= ST_NORMAL;
               ack_q  <= ack_dec;
               hold_q <= ~ack_dec;
            end
            default: st <= ST_NORMAL;
         endcase
      end
   end

   // R3: an accepted write moves normal to entering
   assert_enter_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_NORMAL && entry_go) |=> st == ST_ENTER);
   // R6: without an unblocked wake the device stays idle
   assert_stay_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && !wake) |=> st == ST_IDLE);
   // R8: at most one decision pulse
   assert_one_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ack_q, hold_q}));
   // R7: a decision pulse comes only with the idle-to-normal step
   assert_pulse_on_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && wake) |=> (st == ST_NORMAL && (ack_q || hold_q)));
endmodule

// File: rtl/lp_idle_ctrl.sv
`timescale 1ns/1ps
module lp_idle_ctrl
   import lp_idle_pkg::*;
#(
   parameter int N_EXT       = 8,
   parameter int N_PERIPH    = 4,
   parameter int PRIO_W      = 3,
   parameter int ENTRY_DELAY = 5,
   parameter int SYNC_STAGES = 2,
   parameter int DATA_W      = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_we,
   input  logic                reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   input  logic                nmi_pin,
   input  logic                wdt_irq,
   input  logic [N_EXT-1:0]    ext_irq,
   input  logic [N_EXT-1:0]    ext_irq_en,
   input  logic [N_PERIPH-1:0] periph_irq,
   input  logic                in_service,
   input  logic [PRIO_W-1:0]   svc_level,
   input  logic [PRIO_W-1:0]   req_level,
   output logic                cpu_clk_en,
   output logic                periph_clk_en,
   output logic                osc_en,
   output logic                pll_en,
   output logic                flash_en,
   output logic [1:0]          idle_state,
   output logic                wake_ack,
   output logic                wake_hold
);
   generate
      if (N_EXT < 1 || N_PERIPH < 1 || PRIO_W < 1) begin : g_bad_w
         $error("lp_idle_ctrl: source counts and PRIO_W must be positive");
      end
      if (ENTRY_DELAY < 1) begin : g_bad_d
         $error("lp_idle_ctrl: ENTRY_DELAY must be at least 1");
      end
      if (DATA_W < 4) begin : g_bad_dw
         $error("lp_idle_ctrl: DATA_W must be at least 4");
      end
   endgenerate

   localparam int SYNC_W = N_EXT + 1;

   idle_state_t st;
   logic        entry_go, clr_stop, wake, ack_dec;
   logic        m_nmi, m_wdt, m_mask;
   logic [SYNC_W-1:0] sync_q;

   lp_idle_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({nmi_pin, ext_irq}), .q(sync_q));

   lp_idle_regs #(.DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .is_normal(st == ST_NORMAL), .clr_stop(clr_stop),
      .entry_go(entry_go), .m_nmi(m_nmi), .m_wdt(m_wdt), .m_mask(m_mask),
      .rdata(reg_rdata));

   lp_idle_wake #(.N_EXT(N_EXT), .N_PERIPH(N_PERIPH), .PRIO_W(PRIO_W)) u_wake (
      .nmi_s(sync_q[SYNC_W-1]), .wdt_irq(wdt_irq), .ext_s(sync_q[N_EXT-1:0]),
      .ext_en(ext_irq_en), .periph_irq(periph_irq), .m_nmi(m_nmi),
      .m_wdt(m_wdt), .m_mask(m_mask), .in_service(in_service),
      .svc_level(svc_level), .req_level(req_level), .wake(wake),
      .ack_dec(ack_dec));

   lp_idle_fsm #(.ENTRY_DELAY(ENTRY_DELAY)) u_fsm (
      .clk(clk), .rst_n(rst_n), .entry_go(entry_go), .wake(wake),
      .ack_dec(ack_dec), .st(st), .clr_stop(clr_stop), .ack_q(wake_ack),
      .hold_q(wake_hold));

   assign idle_state    = st;
   assign cpu_clk_en    = (st != ST_IDLE);
   assign periph_clk_en = (st != ST_IDLE);
   assign osc_en        = 1'b1;
   assign pll_en        = 1'b1;
   assign flash_en      = 1'b1;

   // R4: gated domains restart on the step after a wake
   assert_clk_back_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && wake) |=> (cpu_clk_en && periph_clk_en));
endmodule

// File: tb/lp_idle_ctrl_tb_top.sv
`timescale 1ns/1ps
module lp_idle_ctrl_tb_top;
   localparam int NE = 8, NP = 4, PW = 3, DLY = 5, DW = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic reg_we = 0, reg_addr = 0;
   logic [DW-1:0] reg_wdata = '0, reg_rdata;
   logic nmi_pin = 0, wdt_irq = 0, in_service = 0;
   logic [NE-1:0] ext_irq = '0, ext_irq_en = '0;
   logic [NP-1:0] periph_irq = '0;
   logic [PW-1:0] svc_level = '0, req_level = '0;
   logic cpu_clk_en, periph_clk_en, osc_en, pll_en, flash_en, wake_ack, wake_hold;
   logic [1:0] idle_state;
   int total = 0, bad = 0;

   always #2.5 clk = ~clk;

   lp_idle_ctrl #(.N_EXT(NE), .N_PERIPH(NP), .PRIO_W(PW), .ENTRY_DELAY(DLY),
                  .SYNC_STAGES(2), .DATA_W(DW)) dut_i (.*);

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic quiet();
      nmi_pin = 0; wdt_irq = 0; ext_irq = '0; ext_irq_en = '0;
      periph_irq = '0; in_service = 0; svc_level = '0; req_level = '0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      quiet();
      rst_n = 0;
      @(negedge clk); @(negedge clk);
      rst_n = 1;
      @(negedge clk);
   endtask

   task automatic wr(logic a, logic [DW-1:0] d);
      @(negedge clk);
      reg_we = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 0;
   endtask

   task automatic enter(logic [2:0] m);
      wr(1'b0, 4'h0);
      wr(1'b1, {m, 1'b1});
      repeat (DLY) @(negedge clk);
      chk("R3 idle reached", idle_state, 2);
   endtask

   // src: 0 NMI pin, 1 watchdog, 2 external line 0, 3 peripheral 0
   task automatic drive_src(int src);
      case (src)
         0: nmi_pin = 1;
         1: wdt_irq = 1;
         2: begin ext_irq[0] = 1; ext_irq_en[0] = 1; end
         default: periph_irq[0] = 1;
      endcase
   endtask

   initial begin
      #750000;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      do_reset();
      // R1 reset state
      chk("R1 state", idle_state, 0);
      reg_addr = 1; #0.1;
      chk("R1 ctrl reg", reg_rdata, 0);
      reg_addr = 0; #0.1;
      chk("R1 mode reg", reg_rdata, 0);
      chk("R4 cpu en", cpu_clk_en, 1);
      chk("R4 periph en", periph_clk_en, 1);

      // R2 nonzero mode blocks entry
      for (int md = 1; md < 4; md++) begin
         wr(1'b0, 4'(md));
         wr(1'b1, 4'h1);
         @(negedge clk);
         chk("R2 state normal", idle_state, 0);
         reg_addr = 1; #0.1;
         chk("R2 stop stays 0", reg_rdata[0], 0);
      end

      // R3 R4 exact entry timing
      wr(1'b0, 4'h0);
      wr(1'b1, 4'h1);
      chk("R3 entering", idle_state, 1);
      chk("R3 cpu en while entering", cpu_clk_en, 1);
      for (int i = 1; i < DLY; i++) begin
         @(negedge clk);
         chk("R3 still entering", idle_state, 1);
         chk("R3 periph en while entering", periph_clk_en, 1);
      end
      @(negedge clk);
      chk("R3 idle", idle_state, 2);
      chk("R4 cpu gated", cpu_clk_en, 0);
      chk("R4 periph gated", periph_clk_en, 0);
      chk("R4 osc", osc_en, 1);
      chk("R4 pll", pll_en, 1);
      chk("R4 flash", flash_en, 1);

      // R10 asynchronous reset while idle
      #1.0 rst_n = 0; #0.5;
      chk("R10 state normal", idle_state, 0);
      chk("R10 cpu en", cpu_clk_en, 1);
      do_reset();

      // R5 R6 R7 R9 source x mask sweep
      for (int src = 0; src < 4; src++) begin
         for (int m = 0; m < 8; m++) begin
            int blk, lat;
            do_reset();
            enter(3'(m));
            blk = (src == 0) ? m & 1 : (src == 1) ? (m >> 1) & 1 : (m >> 2) & 1;
            lat = (src == 0 || src == 2) ? 3 : 1;
            drive_src(src);
            if (blk == 0) begin
               for (int k = 1; k < lat; k++) begin
                  @(negedge clk);
                  chk("R9 sync latency", idle_state, 2);
               end
               @(negedge clk);
               chk("R5 R7 woke", idle_state, 0);
               chk("R8 ack", wake_ack, 1);
               chk("R8 no hold", wake_hold, 0);
               reg_addr = 1; #0.1;
               chk("R7 stop clear masks kept", reg_rdata, m << 1);
               @(negedge clk);
               chk("R8 ack one cycle", wake_ack, 0);
            end else begin
               repeat (6) @(negedge clk);
               chk("R6 masked stays idle", idle_state, 2);
            end
         end
      end

      // R5 external line enable sweep
      for (int ln = 0; ln < NE; ln++) begin
         for (int en = 0; en < 2; en++) begin
            do_reset();
            enter(3'b000);
            ext_irq[ln] = 1; ext_irq_en[ln] = 1'(en);
            repeat (3) @(negedge clk);
            chk("R5 ext line enable", idle_state, en ? 0 : 2);
         end
      end

      // R8 priority sweep with peripheral wake
      for (int sv = 0; sv < 2; sv++) begin
         for (int s = 0; s < 8; s++) begin
            for (int r = 0; r < 8; r++) begin
               int exp_ack;
               do_reset();
               enter(3'b000);
               in_service = 1'(sv); svc_level = 3'(s); req_level = 3'(r);
               periph_irq[1] = 1;
               exp_ack = (sv == 0 || r > s) ? 1 : 0;
               @(negedge clk);
               chk("R8 exit", idle_state, 0);
               chk("R8 ack", wake_ack, exp_ack);
               chk("R8 hold", wake_hold, 1 - exp_ack);
            end
         end
      end

      // R8 non-maskable wake outranks any service level
      for (int src = 0; src < 2; src++) begin
         do_reset();
         enter(3'b000);
         in_service = 1; svc_level = 3'd7; req_level = 3'd0;
         drive_src(src);
         repeat (src == 0 ? 3 : 1) @(negedge clk);
         chk("R8 nonmaskable ack", wake_ack, 1);
         chk("R8 nonmaskable no hold", wake_hold, 0);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule